// File: doc/BRIEF.md
# Context-Tagged TLB Translation Lookup

This block translates a 64-bit virtual address into a physical address. It searches a fully associative table of translation entries, and every entry is compared in parallel. Each entry carries a 13-bit context tag, a global flag that lets it match any context, a 2-bit page-size field and protection bits. A request also carries an access kind, a user/kernel flag, an address-space selector and a no-fault flag. The block derives the effective context number from the trap level and the selector, then reports a hit, a miss, a protection fault or a no-fault zero completion.

A request is captured on one clock edge, together with the context registers, trap level and enable controls present at that edge. The lookup runs on the captured values, and the result is registered on the following edge. Entries are loaded through a single write port. When translation is off for the access side, the address passes through unchanged.

Top module: `tlb_xlate_lookup`

## Requirements
- R1: A write with `wr_en` stores `wr_tag` and `wr_data` into entry `wr_idx`. The tag holds the virtual page in bits 63:13 and the context in bits 12:0. The data holds valid in bit 63, size in 62:61, the physical page in bits PA_W-1:13, privileged in bit 2, writable in bit 1 and global in bit 0. On a hit, `rsp_pa` takes the entry's page bits above the page offset and the request's address bits inside the offset.
- R2: All ENTRIES entries are searched on every lookup. When several entries match, the lowest-indexed one supplies the result.
- R3: A non-global entry matches only when its tag bits 12:0 equal the effective context. A global entry matches under any context.
- R4: Size code s (0..3) gives pages of 8 KB, 64 KB, 512 KB and 4 MB. Virtual address bits at and above 13+3*s are compared, and the bits below them are the offset.
- R5: The effective context is 0 when the trap level is nonzero. For data accesses it is also 0 when `req_space` bit 1 (nucleus) is set. Otherwise a data access with `req_space` bit 0 set uses `sec_ctx`, and any other access uses `prim_ctx`. Fetches (`req_kind`=00) ignore `req_space`.
- R6: A hit faults (`rsp_fault`=1) when the entry is privileged and `req_user` is set, or when the access is a store (`req_kind`=10) and the entry is not writable.
- R7: A miss raises `rsp_miss` with `rsp_pa`=0. A load (`req_kind` 01 or 11) with `req_nofault` set that misses instead raises `rsp_nf_zero` with `rsp_pa`=0, and it raises neither miss nor fault.
- R8: Data accesses bypass translation when `data_xlate_en`=0. Fetches bypass when `fetch_xlate_en`=0 or when `fetch_reset_state`=1. A bypass returns hit=1, fault=0 and `rsp_pa` = the low PA_W bits of the virtual address.
- R9: `rsp_valid` rises two clock edges after the edge that samples `req_valid`. When `rsp_valid` is low, all result flags are low. Reset clears `rsp_valid` and invalidates every entry.
- R10: An entry whose valid bit is clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_tag | input | VA_W | Tag: virtual page and context |
| wr_data | input | 64 | Data: valid, size, physical page, permissions, global |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| req_user | input | 1 | User-mode access |
| req_space | input | 2 | Bit 0 secondary, bit 1 nucleus |
| req_nofault | input | 1 | Non-faulting load |
| trap_lvl | input | TL_W | Current trap level |
| prim_ctx | input | 13 | Primary context number |
| sec_ctx | input | 13 | Secondary context number |
| data_xlate_en | input | 1 | Data translation enable |
| fetch_xlate_en | input | 1 | Fetch translation enable |
| fetch_reset_state | input | 1 | Forces fetch bypass |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation found or bypassed |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Protection fault |
| rsp_nf_zero | output | 1 | No-fault load missed, result is zero |
| rsp_pa | output | PA_W | Physical address |

## Verification
The bench places entries of all four sizes and probes the last offset inside each page and the first address beyond it. A wrong mask shift would show up there as a hit past the page end or a miss inside it. A global entry is probed under a foreign context, and a design that ignored the global flag would miss. Context selection is exercised under a nonzero trap level, a nucleus selector and a secondary selector on a fetch, where picking the wrong context register turns hits into misses. Two entries are given the same page, so taking the higher index shows up as the wrong physical address. No-fault stores, bypass while an entry is read-only, and the fetch reset-state flag are also covered; a design that mixed up these paths would report a spurious fault or miss.

// File: rtl/tlb_lookup_pkg.sv
// Shared constants and encodings for the context-tagged translation lookup.
// Assumes the context field fits below the smallest page offset.
package tlb_lookup_pkg;
    localparam int CTX_W      = 13;
    localparam int PAGE_SHIFT = 13;
    localparam int SIZE_STEP  = 3;
    localparam int VALID_BIT  = 63;
    localparam int SIZE_HI    = 62;
    localparam int SIZE_LO    = 61;
    localparam int PRIV_BIT   = 2;
    localparam int WR_BIT     = 1;
    localparam int GLOB_BIT   = 0;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_LOADX = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/tlb_ctx_pick.sv
// Chooses the effective context number for one lookup.
// Assumes fetches never consult the address-space selector.
module tlb_ctx_pick
    import tlb_lookup_pkg::*;
#(
    parameter int TL_W = 3
) (
    input  logic [1:0]       kind,
    input  logic [1:0]       space,
    input  logic [TL_W-1:0]  trap_lvl,
    input  logic [CTX_W-1:0] prim_ctx,
    input  logic [CTX_W-1:0] sec_ctx,
    output logic [CTX_W-1:0] ctx
);
    logic is_data;
    assign is_data = (kind != KIND_FETCH);

    // Priority: trap level / nucleus, then secondary, then primary.
    always_comb begin
        if ((|trap_lvl) || (is_data && space[1]))
            ctx = '0;
        else if (is_data && space[0])
            ctx = sec_ctx;
        else
            ctx = prim_ctx;
    end
endmodule

// File: rtl/tlb_way_cmp.sv
// Compares one table entry against the lookup address and context.
// Assumes the tag's low CTX_W bits hold the context and lie inside the offset.
module tlb_way_cmp
    import tlb_lookup_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic             ent_valid,
    input  logic [1:0]       ent_size,
    input  logic             ent_glob,
    input  logic [VA_W-1:0]  ent_tag,
    input  logic [VA_W-1:0]  va,
    input  logic [CTX_W-1:0] ctx,
    output logic             hit
);
    logic [VA_W-1:0] page_mask;
    logic            page_eq;
    logic            ctx_eq;

    // Page mask grows by three bits per size step.
    always_comb page_mask = {VA_W{1'b1}} << (PAGE_SHIFT + SIZE_STEP * int'(ent_size));
    // Virtual page and context comparison.
    always_comb begin
        page_eq = (((va ^ ent_tag) & page_mask) == '0);
        ctx_eq  = ent_glob || (ent_tag[CTX_W-1:0] == ctx);
        hit     = ent_valid && page_eq && ctx_eq;
    end
endmodule

// File: rtl/tlb_first_hit.sv
// Reduces a hit vector to the lowest set index.
// Assumes N >= 2.
module tlb_first_hit #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so the lowest hit is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
        any = |hits;
    end
endmodule

// File: rtl/tlb_xlate_lookup.sv
// Fully associative context-tagged translation lookup with a write port.
// Request is registered, looked up combinationally, result registered next edge.
// Assumes PA_W <= 61 and ENTRIES is a power of two.
module tlb_xlate_lookup
    import tlb_lookup_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 64,
    parameter int PA_W    = 41,
    parameter int TL_W    = 3,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PPN_W  = PA_W - PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_tag,
    input  logic [63:0]      wr_data,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    input  logic [1:0]       req_space,
    input  logic             req_nofault,
    input  logic [TL_W-1:0]  trap_lvl,
    input  logic [CTX_W-1:0] prim_ctx,
    input  logic [CTX_W-1:0] sec_ctx,
    input  logic             data_xlate_en,
    input  logic             fetch_xlate_en,
    input  logic             fetch_reset_state,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic             rsp_nf_zero,
    output logic [PA_W-1:0]  rsp_pa
);
    // Entry storage, split by field.
    logic [VA_W-1:0]  ent_tag  [ENTRIES];
    logic [PPN_W-1:0] ent_ppn  [ENTRIES];
    logic [1:0]       ent_size [ENTRIES];
    logic [ENTRIES-1:0] ent_valid, ent_glob, ent_priv, ent_wr;

    // Data bits with no meaning in this block.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[60:PA_W], wr_data[PAGE_SHIFT-1:3]};

    // Valid bits: cleared by reset, set or cleared by writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ent_valid <= '0;
        else if (wr_en)
            ent_valid[wr_idx] <= wr_data[VALID_BIT];
    end

    // Entry payload written without reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_tag[wr_idx]  <= wr_tag;
            ent_ppn[wr_idx]  <= wr_data[PA_W-1:PAGE_SHIFT];
            ent_size[wr_idx] <= wr_data[SIZE_HI:SIZE_LO];
            ent_glob[wr_idx] <= wr_data[GLOB_BIT];
            ent_priv[wr_idx] <= wr_data[PRIV_BIT];
            ent_wr[wr_idx]   <= wr_data[WR_BIT];
        end
    end

    // Request stage registers (request plus the controls it depends on).
    logic             rq_v, rq_user, rq_nf, rq_den, rq_ien, rq_red;
    logic [VA_W-1:0]  rq_va;
    logic [1:0]       rq_kind, rq_space;
    logic [TL_W-1:0]  rq_tl;
    logic [CTX_W-1:0] rq_pctx, rq_sctx;

    // Capture the request and its controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_v <= 1'b0;
        end else begin
            rq_v <= req_valid;
        end
        rq_va    <= req_va;
        rq_kind  <= req_kind;
        rq_user  <= req_user;
        rq_space <= req_space;
        rq_nf    <= req_nofault;
        rq_tl    <= trap_lvl;
        rq_pctx  <= prim_ctx;
        rq_sctx  <= sec_ctx;
        rq_den   <= data_xlate_en;
        rq_ien   <= fetch_xlate_en;
        rq_red   <= fetch_reset_state;
    end

    logic [CTX_W-1:0] eff_ctx;
    tlb_ctx_pick #(.TL_W(TL_W)) i_ctx (
        .kind(rq_kind), .space(rq_space), .trap_lvl(rq_tl),
        .prim_ctx(rq_pctx), .sec_ctx(rq_sctx), .ctx(eff_ctx)
    );

    logic [ENTRIES-1:0] way_hit;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_way
        tlb_way_cmp #(.VA_W(VA_W)) i_way (
            .ent_valid(ent_valid[g]), .ent_size(ent_size[g]), .ent_glob(ent_glob[g]),
            .ent_tag(ent_tag[g]), .va(rq_va), .ctx(eff_ctx), .hit(way_hit[g])
        );
    end

    logic             any_hit;
    logic [IDX_W-1:0] sel;
    tlb_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) i_pick (
        .hits(way_hit), .any(any_hit), .idx(sel)
    );

    logic            bypass, perm_fault, nf_ok;
    logic [PA_W-1:0] off_mask, hit_pa;

    // Bypass, physical address assembly and permission check.
    always_comb begin
        bypass   = (rq_kind == KIND_FETCH) ? (!rq_ien || rq_red) : !rq_den;
        off_mask = ~({PA_W{1'b1}} << (PAGE_SHIFT + SIZE_STEP * int'(ent_size[sel])));
        hit_pa   = ({ent_ppn[sel], {PAGE_SHIFT{1'b0}}} & ~off_mask)
                 | (rq_va[PA_W-1:0] & off_mask);
        perm_fault = (ent_priv[sel] && rq_user)
                   || (rq_kind == KIND_STORE && !ent_wr[sel]);
        nf_ok    = rq_nf && rq_kind[0];
    end

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n || !rq_v) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_nf_zero <= 1'b0;
            rsp_pa      <= '0;
        end else begin
            rsp_valid   <= 1'b1;
            rsp_hit     <= bypass || any_hit;
            rsp_fault   <= !bypass && any_hit && perm_fault;
            rsp_miss    <= !bypass && !any_hit && !nf_ok;
            rsp_nf_zero <= !bypass && !any_hit && nf_ok;
            rsp_pa      <= bypass ? rq_va[PA_W-1:0] : (any_hit ? hit_pa : '0);
        end
    end
endmodule

// File: rtl/tlb_xlate_lookup_chk.sv
// Temporal checks on the lookup result interface; bound to the top module.
module tlb_xlate_lookup_chk #(
    parameter int PA_W = 41
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic            rsp_nf_zero,
    input logic [PA_W-1:0] rsp_pa
);
    // R9: a sampled request yields a result two edges later.
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    // R9: no flags without a valid result.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault || rsp_nf_zero));

    // R7: exactly one of hit, miss, no-fault zero per result.
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_nf_zero}) == 1);

    // R6: a fault only accompanies a hit.
    p_fault_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);

    // R7: no-fault completion returns zero and no fault.
    p_nf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nf_zero |-> (rsp_pa == '0) && !rsp_fault);

    // R7: a miss returns a zero address.
    p_miss_pa_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> rsp_pa == '0);
endmodule

bind tlb_xlate_lookup tlb_xlate_lookup_chk #(.PA_W(PA_W)) i_chk (.*);

// File: tb/test_tlb_xlate_lookup.sv
// Self-checking bench: directed corner cases plus seeded random lookups.
module test_tlb_xlate_lookup;
    localparam int N    = 64;
    localparam int PA_W = 41;
    localparam int TL_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0, wr_data = '0;
    logic req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0] req_kind = 2'b01, req_space = 2'b00;
    logic req_user = 1'b0, req_nofault = 1'b0;
    logic [TL_W-1:0] trap_lvl = '0;
    logic [12:0] prim_ctx = 13'd5, sec_ctx = 13'd9;
    logic data_xlate_en = 1'b1, fetch_xlate_en = 1'b1, fetch_reset_state = 1'b0;
    logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_nf_zero;
    logic [PA_W-1:0] rsp_pa;

    int total = 0;
    int bad = 0;
    logic [63:0] m_tag [N];
    logic [63:0] m_data[N];

    always #5 clk = ~clk;

    tlb_xlate_lookup i_tlb_xlate_lookup (.*);

    function automatic logic [63:0] mk(input logic v, input logic [1:0] sz,
            input logic [63:0] pa, input logic pr, input logic w, input logic gl);
        logic [63:0] d = '0;
        d[63] = v; d[62:61] = sz; d[PA_W-1:13] = pa[PA_W-1:13];
        d[2] = pr; d[1] = w; d[0] = gl;
        return d;
    endfunction

    // Expected {valid,hit,miss,fault,nf_zero,pa} from the requirements.
    function automatic logic [PA_W+4:0] expect_rsp(input logic [63:0] va,
            input logic [1:0] kind, input logic user, input logic [1:0] sp, input logic nf);
        logic byp, h, f, z, ms;
        logic [12:0] ctx;
        logic [63:0] mask, pa;
        byp = (kind == 2'b00) ? (!fetch_xlate_en || fetch_reset_state) : !data_xlate_en;
        if (byp) return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, va[PA_W-1:0]};
        if (trap_lvl != 0 || (kind != 2'b00 && sp[1])) ctx = 13'd0;
        else if (kind != 2'b00 && sp[0]) ctx = sec_ctx;
        else ctx = prim_ctx;
        h = 1'b0; f = 1'b0; pa = '0;
        for (int i = 0; i < N; i++) begin
            mask = 64'hFFFF_FFFF_FFFF_FFFF << (13 + 3 * int'(m_data[i][62:61]));
            if (!h && m_data[i][63] && ((va & mask) == (m_tag[i] & mask))
                    && (m_data[i][0] || m_tag[i][12:0] == ctx)) begin
                h  = 1'b1;
                pa = (m_data[i] & mask) | (va & ~mask);
                f  = (m_data[i][2] && user) || (kind == 2'b10 && !m_data[i][1]);
            end
        end
        z  = !h && nf && kind[0];
        ms = !h && !z;
        return {1'b1, h, ms, f, z, pa[PA_W-1:0]};
    endfunction

    task automatic check(input string rq, input logic [PA_W+4:0] act, input logic [PA_W+4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic write_ent(input int idx, input logic [63:0] tag, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_tag = tag; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_tag[idx] = tag; m_data[idx] = d;
    endtask

    task automatic look(input string rq, input logic [63:0] va, input logic [1:0] kind,
            input logic user, input logic [1:0] sp, input logic nf);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_kind = kind;
        req_user = user; req_space = sp; req_nofault = nf;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(rq, {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_nf_zero, rsp_pa},
              expect_rsp(va, kind, user, sp, nf));
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] va_a, base;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 reset", {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_nf_zero, rsp_pa}, '0);
        // R10/R9: empty table misses
        look("R10 empty table", 64'h0000_0010_0000_2000, 2'b01, 1'b0, 2'b00, 1'b0);
        // R1: basic hit and address assembly
        va_a = 64'h0000_0040_0000_0000;
        write_ent(0, va_a | 64'd5, mk(1, 0, 64'h1_2345_6000, 0, 1, 0));
        look("R1 basic hit", va_a | 64'h123, 2'b01, 1'b1, 2'b00, 1'b0);
        look("R1 store hit", va_a | 64'h1ff8, 2'b10, 1'b0, 2'b00, 1'b0);
        // R10: invalid entry
        write_ent(1, 64'h0000_0050_0000_0000 | 64'd5, mk(0, 0, 64'h3_0000_0000, 0, 1, 0));
        look("R10 invalid entry", 64'h0000_0050_0000_0010, 2'b01, 1'b0, 2'b00, 1'b0);
        // R4: four page sizes, last inside offset and first beyond
        for (int s = 0; s < 4; s++) begin
            base = 64'h0000_0100_0000_0000 + 64'(s) * 64'h100_0000;
            write_ent(2 + s, base | 64'd5, mk(1, 2'(s), 64'h1_8000_0000 + 64'(s) * 64'h80_0000, 0, 1, 0));
            look("R4 page last byte", base + (64'h2000 << (3 * s)) - 64'd8, 2'b01, 1'b0, 2'b00, 1'b0);
            look("R4 page end+1", base + (64'h2000 << (3 * s)), 2'b01, 1'b0, 2'b00, 1'b0);
        end
        // R3: context and global
        write_ent(6, 64'h0000_0200_0000_0000 | 64'd7, mk(1, 0, 64'h2_0000_0000, 0, 1, 0));
        look("R3 foreign ctx miss", 64'h0000_0200_0000_0040, 2'b01, 1'b0, 2'b00, 1'b0);
        write_ent(7, 64'h0000_0210_0000_0000 | 64'd7, mk(1, 0, 64'h2_1000_0000, 0, 1, 1));
        look("R3 global hit", 64'h0000_0210_0000_0040, 2'b01, 1'b0, 2'b00, 1'b0);
        // R5: context selection
        write_ent(8, 64'h0000_0300_0000_0000 | 64'd9, mk(1, 0, 64'h3_1000_0000, 0, 1, 0));
        look("R5 secondary hit", 64'h0000_0300_0000_0008, 2'b01, 1'b0, 2'b01, 1'b0);
        look("R5 primary miss", 64'h0000_0300_0000_0008, 2'b01, 1'b0, 2'b00, 1'b0);
        look("R5 fetch ignores space", 64'h0000_0300_0000_0008, 2'b00, 1'b0, 2'b01, 1'b0);
        write_ent(9, 64'h0000_0310_0000_0000, mk(1, 1, 64'h3_2000_0000, 0, 1, 0));
        look("R5 nucleus hit", 64'h0000_0310_0000_4008, 2'b01, 1'b0, 2'b10, 1'b0);
        trap_lvl = 3'd1;
        look("R5 trap level ctx0", 64'h0000_0310_0000_4008, 2'b00, 1'b0, 2'b00, 1'b0);
        look("R5 trap level over sec", 64'h0000_0300_0000_0008, 2'b01, 1'b0, 2'b01, 1'b0);
        trap_lvl = '0;
        // R6: permissions
        write_ent(10, 64'h0000_0400_0000_0000 | 64'd5, mk(1, 0, 64'h4_0000_0000, 1, 0, 0));
        look("R6 user on priv", 64'h0000_0400_0000_0010, 2'b01, 1'b1, 2'b00, 1'b0);
        look("R6 kernel load ok", 64'h0000_0400_0000_0010, 2'b01, 1'b0, 2'b00, 1'b0);
        look("R6 store readonly", 64'h0000_0400_0000_0010, 2'b10, 1'b0, 2'b00, 1'b0);
        look("R6 fetch readonly ok", 64'h0000_0400_0000_0010, 2'b00, 1'b0, 2'b00, 1'b0);
        // R7: no-fault loads
        look("R7 nofault miss", 64'h0000_0777_0000_0000, 2'b01, 1'b0, 2'b00, 1'b1);
        look("R7 nofault alt load", 64'h0000_0777_0000_0000, 2'b11, 1'b0, 2'b00, 1'b1);
        look("R7 nofault store miss", 64'h0000_0777_0000_0000, 2'b10, 1'b0, 2'b00, 1'b1);
        look("R7 nofault hit", va_a | 64'h20, 2'b01, 1'b0, 2'b00, 1'b1);
        // R2: lowest index wins
        write_ent(20, 64'h0000_0500_0000_0000 | 64'd5, mk(1, 0, 64'h5_0000_0000, 0, 1, 0));
        write_ent(30, 64'h0000_0500_0000_0000 | 64'd5, mk(1, 0, 64'h6_0000_0000, 0, 1, 0));
        look("R2 lowest index", 64'h0000_0500_0000_0100, 2'b01, 1'b0, 2'b00, 1'b0);
        write_ent(63, 64'h0000_0600_0000_0000 | 64'd5, mk(1, 3, 64'h7_0000_0000, 0, 1, 0));
        look("R2 last entry", 64'h0000_0600_0012_3450, 2'b01, 1'b0, 2'b00, 1'b0);
        // R8: bypass paths
        data_xlate_en = 1'b0;
        look("R8 data bypass", 64'h0000_0777_1234_5678, 2'b01, 1'b0, 2'b00, 1'b0);
        look("R8 bypass no fault", 64'h0000_0400_0000_0010, 2'b10, 1'b1, 2'b00, 1'b0);
        look("R8 fetch still maps", 64'h0000_0777_0000_0000, 2'b00, 1'b0, 2'b00, 1'b0);
        data_xlate_en = 1'b1;
        fetch_xlate_en = 1'b0;
        look("R8 fetch bypass", 64'h0000_0777_0000_4444, 2'b00, 1'b0, 2'b00, 1'b0);
        fetch_xlate_en = 1'b1;
        fetch_reset_state = 1'b1;
        look("R8 reset-state bypass", 64'h0000_0777_0000_8888, 2'b00, 1'b0, 2'b00, 1'b0);
        look("R8 reset-state data maps", 64'h0000_0777_0000_8888, 2'b01, 1'b0, 2'b00, 1'b0);
        fetch_reset_state = 1'b0;
        // Random: rewrite the whole table, then random lookups (R1-style checks)
        for (int i = 0; i < N; i++) begin
            logic [12:0] cx;
            case ($urandom % 4) 0: cx = 13'd0; 1: cx = 13'd5; 2: cx = 13'd9; default: cx = 13'd3; endcase
            write_ent(i, 64'h0000_7000_0000_0000 | (64'($urandom % 16) << 22) | 64'(cx),
                      mk(($urandom % 8) != 0, 2'($urandom), {32'h0, $urandom} << 12,
                         1'($urandom), 1'($urandom), ($urandom % 6) == 0));
        end
        for (int k = 0; k < 400; k++) begin
            trap_lvl = (($urandom % 5) == 0) ? 3'd2 : 3'd0;
            prim_ctx = (($urandom % 2) == 0) ? 13'd5 : 13'd3;
            sec_ctx  = (($urandom % 2) == 0) ? 13'd9 : 13'd0;
            data_xlate_en = ($urandom % 10) != 0;
            fetch_xlate_en = ($urandom % 10) != 0;
            fetch_reset_state = ($urandom % 12) == 0;
            look("R1 random", 64'h0000_7000_0000_0000 | (64'($urandom % 20) << 22) | 64'($urandom % 32'h40_0000),
                 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule